// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block watches the already synchronized input pins of one GPIO port and turns selected input conditions into one interrupt line for that port. Software programs each pin to respond to a rising edge, a falling edge, any edge, a high level or a low level. A pin whose condition is met sets a status bit. The port interrupt is raised while any status bit whose enable bit is set is high.

Software reaches the block through the simple register bus that the port block uses. The bus has a write strobe, an 8-bit byte offset, 32-bit write data and combinational read data. Each pin takes three bits of a 24-bit type register: polarity, edge mode and any-edge mode, each in its own byte lane. Edge status bits stay set until software clears them by writing 1 to the clear register. A level status bit tracks the input condition, one clock late. The enable bits can be written as a whole word. They can also be written through a masked alias, which changes only the bits that the write selects.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset, reads return 0 from the status register (0x40), the enable register (0x50) and the type register (0x60), and `irq` is low.
- R2: The type register at 0x60 keeps write data bits 23:0 and reads them back. Bits 31:24 read as 0. For pin n, bit n is the polarity, bit 8+n is the edge mode and bit 16+n is the any-edge mode.
- R3: Edge codes, written as (bit 16+n, bit 8+n, bit n), are 011 = rising, 010 = falling and 11x = any edge. A matching transition of pin n, judged against its value at the previous clock edge, sets status bit n at the clock edge that samples the new value. The bit stays set until it is cleared.
- R4: Codes with edge mode 0 are level codes: x01 = high level and x00 = low level. Status bit n then equals the condition sampled at the previous clock edge. A clear has no lasting effect on it.
- R5: A write to 0x70 clears every edge status bit whose write data bit is 1. Bits written 0 keep their value. An edge that arrives after the clear sets the bit again.
- R6: If a qualifying edge and a clear of the same pin come in the same cycle, the status bit is set after that cycle.
- R7: A write to 0x50 loads the enable bits from write data bits 7:0.
- R8: A write to the masked alias at 0xD0 updates enable bit n to write data bit n only where write data bit 8+n is 1. The other enable bits keep their value. A read at 0xD0 returns the enable bits.
- R9: `irq` is high exactly when some pin has both its status bit and its enable bit set.
- R10: The status register is read-only. A write to 0x40 changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Synchronized pin levels of the port |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Port interrupt request |

## Verification
The hardest case to reach is the same-cycle collision: a pin must make a qualifying transition on the very clock edge that also takes a clear write for that pin. The stimulus gets there by driving the new pin levels and the clear write in one cycle, both in directed steps and in pseudo-random sweeps. The sweeps use mixed per-pin codes and frequent clear writes of random masks, so collisions, sticky holds and re-sets after a clear all occur across all five codes on every pin.

// File: rtl/irqdet_pkg.sv
package irqdet_pkg;

    localparam int BUS_DW = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_STATUS     = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_ENABLE     = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_TYPE       = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_CLEAR      = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_ENABLE_MSK = 8'hD0;

    // Per-pin trigger configuration gathered from three byte lanes.
    typedef struct packed {
        logic any_edge;
        logic edge_mode;
        logic pol;
    } trig_cfg_t;

    typedef enum logic [1:0] {
        DET_LEVEL,
        DET_RISE,
        DET_FALL,
        DET_ANY
    } det_kind_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } transition_t;

    function automatic det_kind_e classify(trig_cfg_t c);
        if (!c.edge_mode)
            return DET_LEVEL;
        else if (c.any_edge)
            return DET_ANY;
        else if (c.pol)
            return DET_RISE;
        else
            return DET_FALL;
    endfunction

    function automatic trig_cfg_t pick_cfg(logic [23:0] t, int unsigned n);
        trig_cfg_t c;
        c.pol       = t[n];
        c.edge_mode = t[8 + n];
        c.any_edge  = t[16 + n];
        return c;
    endfunction

endpackage

// File: rtl/irqdet_pin.sv
module irqdet_pin
    import irqdet_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_now,
    input  logic      pin_prev,
    input  trig_cfg_t cfg,
    input  logic      clr,
    output logic      stat_o
);

    det_kind_e   kind;
    transition_t tr;
    logic        hit;
    logic        lvl_match;
    logic        stat_q;

    always_comb begin
        kind    = classify(cfg);
        tr.rise = pin_now & ~pin_prev;
        tr.fall = ~pin_now & pin_prev;
        unique case (kind)
            DET_RISE: hit = tr.rise;
            DET_FALL: hit = tr.fall;
            DET_ANY:  hit = tr.rise | tr.fall;
            default:  hit = 1'b0;
        endcase
        lvl_match = cfg.pol ? pin_now : ~pin_now;
    end

    // Level pins track the condition; edge pins hold until cleared, a new edge beats a clear.
    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= 1'b0;
        else if (kind == DET_LEVEL)
            stat_q <= lvl_match;
        else
            stat_q <= hit | (stat_q & ~clr);
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/irqdet_regs.sv
module irqdet_regs
    import irqdet_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_DW-1:0]   bus_wdata,
    input  logic [NPINS-1:0]    stat_i,
    output logic [NPINS-1:0]    en_o,
    output logic [3*NPINS-1:0]  type_o,
    output logic [NPINS-1:0]    clr_o,
    output logic [BUS_DW-1:0]   rdata_o
);

    localparam int TW = 3 * NPINS;

    logic [NPINS-1:0] en_q;
    logic [TW-1:0]    type_q;
    logic [NPINS-1:0] msk_sel;
    logic [NPINS-1:0] msk_val;

    assign msk_sel = bus_wdata[2*NPINS-1:NPINS];
    assign msk_val = bus_wdata[NPINS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            type_q <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                OFS_ENABLE:     en_q   <= bus_wdata[NPINS-1:0];
                OFS_ENABLE_MSK: en_q   <= (en_q & ~msk_sel) | (msk_val & msk_sel);
                OFS_TYPE:       type_q <= bus_wdata[TW-1:0];
                default:        ;
            endcase
        end
    end

    assign clr_o = (bus_wr && bus_addr == OFS_CLEAR) ? bus_wdata[NPINS-1:0] : '0;

    always_comb begin
        rdata_o = '0;
        unique case (bus_addr)
            OFS_STATUS:                 rdata_o[NPINS-1:0] = stat_i;
            OFS_ENABLE, OFS_ENABLE_MSK: rdata_o[NPINS-1:0] = en_q;
            OFS_TYPE:                   rdata_o[TW-1:0]    = type_q;
            default:                    rdata_o            = '0;
        endcase
    end

    assign en_o   = en_q;
    assign type_o = type_q;

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
    import irqdet_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pin_in,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    localparam int TW = 3 * NPINS;

    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] en_q;
    logic [TW-1:0]    type_q;
    logic [NPINS-1:0] clr_v;
    logic [NPINS-1:0] stat_q;

    // Previous sample follows the pins even in reset, so the first cycle sees no false edge.
    always_ff @(posedge clk) begin
        prev_q <= pin_in;
    end

    irqdet_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .stat_i    (stat_q),
        .en_o      (en_q),
        .type_o    (type_q),
        .clr_o     (clr_v),
        .rdata_o   (bus_rdata)
    );

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        trig_cfg_t cfg_n;
        assign cfg_n.pol       = type_q[n];
        assign cfg_n.edge_mode = type_q[NPINS + n];
        assign cfg_n.any_edge  = type_q[2*NPINS + n];

        irqdet_pin u_pin (
            .clk      (clk),
            .rst      (rst),
            .pin_now  (pin_in[n]),
            .pin_prev (prev_q[n]),
            .cfg      (cfg_n),
            .clr      (clr_v[n]),
            .stat_o   (stat_q[n])
        );
    end

    assign irq = |(stat_q & en_q);

endmodule

// File: rtl/irqdet_chk.sv
module irqdet_chk
    import irqdet_pkg::*;
#(
    parameter int NPINS = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [NPINS-1:0]   pin_in,
    input logic               bus_wr,
    input logic [7:0]         bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [NPINS-1:0]   en_q,
    input logic [3*NPINS-1:0] type_q,
    input logic [NPINS-1:0]   stat_q
);

    logic [NPINS-1:0] seen_q;
    logic [NPINS-1:0] hit_v;
    logic [NPINS-1:0] clr_hit;

    always_ff @(posedge clk) begin
        seen_q <= pin_in;
    end

    always_comb begin
        for (int n = 0; n < NPINS; n++) begin
            if (!type_q[NPINS + n])
                hit_v[n] = 1'b0;
            else if (type_q[2*NPINS + n])
                hit_v[n] = pin_in[n] ^ seen_q[n];
            else if (type_q[n])
                hit_v[n] = pin_in[n] & ~seen_q[n];
            else
                hit_v[n] = ~pin_in[n] & seen_q[n];
            clr_hit[n] = bus_wr && (bus_addr == OFS_CLEAR) && bus_wdata[n];
        end
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (en_q == '0 && stat_q == '0 && type_q == '0));

    for (genvar n = 0; n < NPINS; n++) begin : g_chk
        assert_edge_set_R3: assert property (@(posedge clk) disable iff (rst)
            (hit_v[n] && !clr_hit[n]) |=> stat_q[n]);

        assert_level_track_R4: assert property (@(posedge clk) disable iff (rst)
            !type_q[NPINS + n] |=> (stat_q[n] == $past(type_q[n] ? pin_in[n] : !pin_in[n])));

        assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
            (type_q[NPINS + n] && clr_hit[n] && !hit_v[n]) |=> !stat_q[n]);

        assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
            (type_q[NPINS + n] && stat_q[n] && !clr_hit[n]) |=> stat_q[n]);

        assert_edge_wins_R6: assert property (@(posedge clk) disable iff (rst)
            (hit_v[n] && clr_hit[n]) |=> stat_q[n]);

        assert_alias_keep_R8: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == OFS_ENABLE_MSK && !bus_wdata[NPINS + n]) |=> $stable(en_q[n]));
    end

endmodule

bind pin_irq_detect irqdet_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pin_in    (pin_in),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .en_q      (en_q),
    .type_q    (type_q),
    .stat_q    (stat_q)
);

// File: tb/test_pin_irq_detect.sv
module test_pin_irq_detect;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pin_in = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h40;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // Reference state derived from the requirements
    logic [7:0]  m_stat = '0;
    logic [7:0]  m_en   = '0;
    logic [23:0] m_type = '0;
    logic [7:0]  m_prev = '0;
    logic [15:0] lfsr   = 16'hACE1;

    always #10 clk = ~clk;

    pin_irq_detect i_pin_irq_detect (
        .clk       (clk),
        .rst       (rst),
        .pin_in    (pin_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, act=timeout exp=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lfsr_next(logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // One clock edge of the reference, per the requirements
    task automatic model_tick(input logic [7:0] in, input logic w, input logic [7:0] a,
                              input logic [31:0] d);
        logic [7:0] nst;
        for (int n = 0; n < 8; n++) begin
            logic r, f, h, c;
            r = in[n] & ~m_prev[n];
            f = ~in[n] & m_prev[n];
            c = w && (a == 8'h70) && d[n];
            if (!m_type[8 + n])
                nst[n] = m_type[n] ? in[n] : ~in[n];
            else begin
                h = m_type[16 + n] ? (r | f) : (m_type[n] ? r : f);
                nst[n] = h | (m_stat[n] & ~c);
            end
        end
        m_stat = nst;
        m_prev = in;
        if (w) begin
            if (a == 8'h50) m_en = d[7:0];
            if (a == 8'hD0) m_en = (m_en & ~d[15:8]) | (d[7:0] & d[15:8]);
            if (a == 8'h60) m_type = d[23:0];
        end
    endtask

    // Drive one cycle (called in the low phase), then check status and irq.
    task automatic step(input logic [7:0] in, input logic w, input logic [7:0] a,
                        input logic [31:0] d, input string tag);
        pin_in    = in;
        bus_wr    = w;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        model_tick(in, w, a, d);
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = 8'h40;
        #1;
        chk(tag, bus_rdata, {24'h0, m_stat});
        chk("R9 irq", {31'h0, irq}, {31'h0, |(m_stat & m_en)});
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_wr   = 1'b0;
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic [23:0] code_all(int k);
        logic [2:0] c;
        case (k)
            0: c = 3'b011;
            1: c = 3'b010;
            2: c = 3'b110;
            3: c = 3'b001;
            default: c = 3'b000;
        endcase
        return {{8{c[2]}}, {8{c[1]}}, {8{c[0]}}};
    endfunction

    function automatic logic [23:0] code_mixed(int shift);
        logic [23:0] t;
        t = '0;
        for (int n = 0; n < 8; n++) begin
            logic [2:0] c;
            case ((n + shift) % 5)
                0: c = 3'b011;
                1: c = 3'b010;
                2: c = 3'b110;
                3: c = 3'b001;
                default: c = 3'b000;
            endcase
            t[n] = c[0];
            t[8 + n] = c[1];
            t[16 + n] = c[2];
        end
        return t;
    endfunction

    initial begin
        logic [31:0] v;
        logic [7:0]  cur;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_prev = '0;

        // R1: reset values
        rd(8'h40, v); chk("R1 status", v, 32'h0);
        rd(8'h50, v); chk("R1 enable", v, 32'h0);
        rd(8'h60, v); chk("R1 type", v, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R2: type register width and readback
        step(8'h00, 1'b1, 8'h60, 32'hFFA5C33C, "R2 write");
        rd(8'h60, v); chk("R2 type readback", v, 32'h00A5C33C);

        // R7: plain enable write
        step(8'h00, 1'b1, 8'h50, 32'h0000_00FF, "R7 write");
        rd(8'h50, v); chk("R7 enable", v, 32'h0000_00FF);

        // R3 / R4: every code on all pins with random pins and clears
        cur = 8'h00;
        for (int k = 0; k < 5; k++) begin
            string tag;
            tag = (k < 3) ? "R3 edge sweep" : "R4 level sweep";
            step(cur, 1'b1, 8'h60, {8'h0, code_all(k)}, tag);
            step(cur, 1'b1, 8'h70, 32'hFF, "R5 clear all");
            for (int s = 0; s < 48; s++) begin
                lfsr = lfsr_next(lfsr);
                cur  = lfsr[7:0];
                if (s % 4 == 3)
                    step(cur, 1'b1, 8'h70, {24'h0, lfsr[15:8]}, "R5 clear in sweep");
                else
                    step(cur, 1'b0, 8'h40, 32'h0, tag);
            end
        end

        // Mixed per-pin codes with partial enables
        step(cur, 1'b1, 8'h50, 32'h5A, "R7 write");
        for (int sh = 0; sh < 5; sh++) begin
            step(cur, 1'b1, 8'h60, {8'h0, code_mixed(sh)}, "R2 mixed write");
            for (int s = 0; s < 40; s++) begin
                lfsr = lfsr_next(lfsr);
                cur  = lfsr[7:0];
                if (s % 3 == 0)
                    step(cur, 1'b1, 8'h70, {24'h0, lfsr[15:8]}, "R6 mixed clear");
                else
                    step(cur, 1'b0, 8'h40, 32'h0, "R3 mixed");
            end
        end

        // R5 / R6 directed: rising on all pins
        step(8'h00, 1'b1, 8'h60, {8'h0, code_all(0)}, "R3 set rising");
        step(8'h00, 1'b1, 8'h70, 32'hFF, "R5 clear");
        chk("R5 cleared", {24'h0, m_stat}, 32'h0);
        step(8'hFF, 1'b1, 8'h70, 32'hFF, "R6 edge with clear");
        chk("R6 edge wins", {24'h0, m_stat}, 32'hFF);
        step(8'hFF, 1'b1, 8'h70, 32'h00, "R5 zero clear no effect");
        step(8'hFF, 1'b1, 8'h70, 32'h0F, "R5 partial clear");
        rd(8'h40, v); chk("R5 partial", v, 32'hF0);
        step(8'h00, 1'b0, 8'h40, 32'h0, "R5 falling ignored by rising");
        step(8'h0F, 1'b0, 8'h40, 32'h0, "R5 re-set after clear");
        rd(8'h40, v); chk("R5 re-set", v, 32'hFF);

        // R10: writing status changes nothing
        step(8'h0F, 1'b1, 8'h70, 32'hFF, "R5 clear");
        step(8'h0F, 1'b1, 8'h40, 32'hFF, "R10 status write");
        rd(8'h40, v); chk("R10 status read-only", v, 32'h00);

        // R8: masked alias
        step(8'h0F, 1'b1, 8'h50, 32'h0F, "R7 write");
        step(8'h0F, 1'b1, 8'hD0, 32'h3CAA, "R8 alias write");
        rd(8'h50, v); chk("R8 alias result", v, 32'h2B);
        rd(8'hD0, v); chk("R8 alias read", v, 32'h2B);
        step(8'h0F, 1'b1, 8'hD0, 32'h00FF, "R8 alias no mask");
        rd(8'h50, v); chk("R8 alias no mask", v, 32'h2B);

        // R9: status set on a disabled pin keeps irq low
        step(8'h0F, 1'b1, 8'h50, 32'h00, "R7 disable");
        step(8'hFF, 1'b0, 8'h40, 32'h0, "R3 edge while disabled");
        chk("R9 disabled irq", {31'h0, irq}, 32'h0);
        step(8'hFF, 1'b1, 8'h50, 32'h80, "R9 enable one");
        chk("R9 enabled irq", {31'h0, irq}, 32'h1);

        // R4: level status ignores clear while condition holds
        step(8'hFF, 1'b1, 8'h60, {8'h0, code_all(3)}, "R4 level high");
        step(8'hFF, 1'b1, 8'h70, 32'hFF, "R4 clear on level");
        rd(8'h40, v); chk("R4 level holds", v, 32'hFF);
        step(8'h00, 1'b0, 8'h40, 32'h0, "R4 level drops");
        rd(8'h40, v); chk("R4 level dropped", v, 32'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule